// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit performs the bit-oriented operations of an 8-bit processor on a single memory operand. A sequencer hands it one operation per request: an operation kind, the opcode byte, the accumulator, an immediate mask, the memory byte, a signed 8-bit displacement and the address of the next instruction. One clock later the unit presents its results for exactly one cycle. These results are the byte to write back with a write strobe, per-flag update enables and values for N, V and Z, and a branch decision with its target address.

One shared datapath covers six operation kinds:
- a test against the accumulator;
- a test against an immediate mask;
- test-and-set and test-and-reset, both with write-back;
- setting or clearing a single numbered bit;
- branching on a single numbered bit.

For the single-bit operations the bit number is opcode bits [6:4], and opcode bit 7 selects the polarity. Memory bus timing, the carry flag and decoding of the rest of the instruction set belong to the surrounding core.

Top module: `bit_test_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `done`, `wr_stb`, all three flag enables and `br_taken` are low.
- R2: Kind 0 (accumulator test) raises all three flag enables, with N = M[7], V = M[6] and Z = 1 exactly when (A AND M) is zero. It raises no write strobe.
- R3: Kind 1 (immediate test) sets N and V as in R2, with Z = 1 exactly when (IMM AND M) is zero. The accumulator has no effect on any output, and no write strobe is raised.
- R4: Kind 2 (test-and-set) raises `wr_stb` and presents A OR M on `wr_data`.
- R5: Kind 3 (test-and-reset) raises `wr_stb` and presents M AND NOT A on `wr_data`.
- R6: For kinds 2 and 3, all three flag enables are high, with V = W[6], N = W[7] and Z = (W == 0), where W is the written byte.
- R7: Kind 4 writes back M with bit n changed, where n = opcode[6:4]. Opcode bit 7 = 1 sets the bit and opcode bit 7 = 0 clears it. No flag enable is raised.
- R8: Kind 5 raises `br_taken` exactly when M[n] equals opcode bit 7, with n = opcode[6:4]. It raises no write strobe and no flag enable.
- R9: For kind 5, `br_target` equals the next-instruction address plus the sign-extended displacement, modulo 65536, whether or not the branch is taken.
- R10: Results appear in the cycle after `op_valid` is sampled high, for that one cycle only. A cycle with `op_valid` low is followed by a cycle with no strobe, enable or branch.
- R11: Kind codes 6 and 7 raise `done` but no write strobe, no flag enable and no branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request this cycle |
| op_kind | input | 3 | Operation kind code (0..5, 6 and 7 unassigned) |
| opcode | input | 8 | Opcode byte; bits [6:4] bit number, bit 7 polarity |
| acc | input | 8 | Accumulator value |
| imm | input | 8 | Immediate mask |
| mem_rd | input | 8 | Memory operand |
| disp | input | 8 | Signed branch displacement |
| pc_next | input | 16 | Address of the following instruction |
| done | output | 1 | Result cycle marker |
| wr_stb | output | 1 | Write-back strobe |
| wr_data | output | 8 | Byte to write back |
| n_we | output | 1 | N flag update enable |
| n_val | output | 1 | New N value |
| v_we | output | 1 | V flag update enable |
| v_val | output | 1 | New V value |
| z_we | output | 1 | Z flag update enable |
| z_val | output | 1 | New Z value |
| br_taken | output | 1 | Branch taken |
| br_target | output | 16 | Branch target address |

## Verification
Test-and-set and test-and-reset produce a write-back strobe and a full flag update in the same result cycle. Both are derived from the written byte rather than from the operand. The sweeps run these kinds over every memory byte against a spread of accumulator values. In each result cycle the bench compares the strobe, the written byte and the N, V and Z values and enables together against values it computes arithmetically. Branch kinds are judged in the same way: taken and target are compared in one cycle, which confirms that a not-taken branch still reports its target and raises no strobe.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [2:0] {
    K_TEST_ACC = 3'd0,
    K_TEST_IMM = 3'd1,
    K_TSET     = 3'd2,
    K_TRST     = 3'd3,
    K_BIT_MOD  = 3'd4,
    K_BIT_BR   = 3'd5
  } bt_kind_e;

  localparam int unsigned OPC_W       = 8;
  localparam int unsigned OPC_IDX_LSB = 4;
  localparam int unsigned OPC_POL_BIT = 7;
endpackage

// File: rtl/bt_bitsel.sv
module bt_bitsel #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  bit_idx,
  output logic [DATA_W-1:0] bit_mask
);
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_dec
    assign bit_mask[gi] = (bit_idx == IDX_W'(gi));
  end
endmodule

// File: rtl/bt_logic.sv
module bt_logic
  import bt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  bt_kind_e          kind,
  input  logic              pol,
  input  logic [DATA_W-1:0] bit_mask,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] imm,
  input  logic [DATA_W-1:0] mem,
  output logic              wr,
  output logic [DATA_W-1:0] wdata,
  output logic              flag_we,
  output logic              n_v,
  output logic              v_v,
  output logic              z_v
);
  logic [DATA_W-1:0] and_src;

  always_comb begin
    wr      = 1'b0;
    wdata   = mem;
    flag_we = 1'b0;
    n_v     = mem[DATA_W-1];
    v_v     = mem[DATA_W-2];
    and_src = acc;
    z_v     = 1'b0;
    unique case (kind)
      K_TEST_ACC, K_TEST_IMM: begin
        and_src = (kind == K_TEST_IMM) ? imm : acc;
        flag_we = 1'b1;
        z_v     = ((and_src & mem) == '0);
      end
      K_TSET, K_TRST: begin
        wr      = 1'b1;
        wdata   = (kind == K_TSET) ? (acc | mem) : (mem & ~acc);
        flag_we = 1'b1;
        n_v     = wdata[DATA_W-1];
        v_v     = wdata[DATA_W-2];
        z_v     = (wdata == '0);
      end
      K_BIT_MOD: begin
        wr    = 1'b1;
        wdata = pol ? (mem | bit_mask) : (mem & ~bit_mask);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bt_branch.sv
module bt_branch #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              is_br,
  input  logic              pol,
  input  logic [DATA_W-1:0] bit_mask,
  input  logic [DATA_W-1:0] mem,
  input  logic [7:0]        disp,
  input  logic [ADDR_W-1:0] pc_next,
  output logic              taken,
  output logic [ADDR_W-1:0] target
);
  logic bit_set;
  logic [ADDR_W-1:0] disp_ext;

  assign bit_set  = |(mem & bit_mask);
  assign taken    = is_br && (bit_set == pol);
  assign disp_ext = {{(ADDR_W-8){disp[7]}}, disp};
  assign target   = pc_next + disp_ext;
endmodule

// File: rtl/bit_test_unit.sv
module bit_test_unit
  import bt_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_kind,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] imm,
  input  logic [DATA_W-1:0] mem_rd,
  input  logic [7:0]        disp,
  input  logic [ADDR_W-1:0] pc_next,
  output logic              done,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic              n_we,
  output logic              n_val,
  output logic              v_we,
  output logic              v_val,
  output logic              z_we,
  output logic              z_val,
  output logic              br_taken,
  output logic [ADDR_W-1:0] br_target
);
  bt_kind_e          kind;
  logic              pol;
  logic [IDX_W-1:0]  bit_idx;
  logic [DATA_W-1:0] bit_mask;
  logic              c_wr, c_fwe, c_n, c_v, c_z, c_taken;
  logic [DATA_W-1:0] c_wdata;
  logic [ADDR_W-1:0] c_target;

  logic              done_d, wr_d, fwe_d, taken_d;

  assign kind    = bt_kind_e'(op_kind);
  assign pol     = opcode[OPC_POL_BIT];
  assign bit_idx = opcode[OPC_IDX_LSB +: IDX_W];

  bt_bitsel #(.DATA_W(DATA_W)) i_bitsel (
    .bit_idx (bit_idx),
    .bit_mask(bit_mask)
  );

  bt_logic #(.DATA_W(DATA_W)) i_logic (
    .kind    (kind),
    .pol     (pol),
    .bit_mask(bit_mask),
    .acc     (acc),
    .imm     (imm),
    .mem     (mem_rd),
    .wr      (c_wr),
    .wdata   (c_wdata),
    .flag_we (c_fwe),
    .n_v     (c_n),
    .v_v     (c_v),
    .z_v     (c_z)
  );

  bt_branch #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_branch (
    .is_br   (kind == K_BIT_BR),
    .pol     (pol),
    .bit_mask(bit_mask),
    .mem     (mem_rd),
    .disp    (disp),
    .pc_next (pc_next),
    .taken   (c_taken),
    .target  (c_target)
  );

  // next-state for the one-cycle control outputs
  always_comb begin
    done_d  = op_valid;
    wr_d    = op_valid && c_wr;
    fwe_d   = op_valid && c_fwe;
    taken_d = op_valid && c_taken;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      wr_stb   <= 1'b0;
      n_we     <= 1'b0;
      v_we     <= 1'b0;
      z_we     <= 1'b0;
      br_taken <= 1'b0;
    end else begin
      done     <= done_d;
      wr_stb   <= wr_d;
      n_we     <= fwe_d;
      v_we     <= fwe_d;
      z_we     <= fwe_d;
      br_taken <= taken_d;
    end
  end

  // data outputs load only when a request is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_data   <= '0;
      n_val     <= 1'b0;
      v_val     <= 1'b0;
      z_val     <= 1'b0;
      br_target <= '0;
    end else if (op_valid) begin
      wr_data   <= c_wdata;
      n_val     <= c_n;
      v_val     <= c_v;
      z_val     <= c_z;
      br_target <= c_target;
    end
  end

  // R4 R5 R7: strobe only after a writing kind
  p_strobe_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(op_valid) && ($past(op_kind) inside {3'd2, 3'd3, 3'd4}));

  // R8: branch only after a branch kind, and never with a strobe
  p_branch_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> $past(op_valid) && ($past(op_kind) == 3'd5) && !wr_stb && !n_we);

  // R10: no activity in a cycle that follows an idle request cycle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !wr_stb && !n_we && !v_we && !z_we && !br_taken);

  // R7: a single-bit modification changes at most one bit of the operand
  p_one_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(op_kind) == 3'd4) |-> ($countones(wr_data ^ $past(mem_rd)) <= 1));

  // R4: test-and-set never clears an operand bit
  p_tset_superset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(op_kind) == 3'd2) |-> ((wr_data & $past(mem_rd)) == $past(mem_rd)));

  // R6: zero result after a modify test means Z is reported set
  p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && n_we && wr_data == '0) |-> z_val);
endmodule

// File: tb/test_bit_test_unit.sv
module test_bit_test_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_kind;
  logic [7:0]  opcode, acc, imm, mem_rd, disp;
  logic [15:0] pc_next;
  logic        done, wr_stb, n_we, n_val, v_we, v_val, z_we, z_val, br_taken;
  logic [7:0]  wr_data;
  logic [15:0] br_target;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bit_test_unit i_bit_test_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .opcode(opcode), .acc(acc), .imm(imm), .mem_rd(mem_rd), .disp(disp),
    .pc_next(pc_next), .done(done), .wr_stb(wr_stb), .wr_data(wr_data),
    .n_we(n_we), .n_val(n_val), .v_we(v_we), .v_val(v_val),
    .z_we(z_we), .z_val(z_val), .br_taken(br_taken), .br_target(br_target)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h (kind %0d op %0h a %0h i %0h m %0h)",
               req, got, exp, op_kind, opcode, acc, imm, mem_rd);
    end
  endtask

  // drive at negedge, outputs register at the next posedge, check at the next negedge
  task automatic issue(input logic [2:0] k, input logic [7:0] o, input logic [7:0] a,
                       input logic [7:0] i, input logic [7:0] m, input logic [7:0] d,
                       input logic [15:0] p);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; opcode = o; acc = a; imm = i; mem_rd = m;
    disp = d; pc_next = p;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    #1_900_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_kind = '0; opcode = '0; acc = '0; imm = '0;
    mem_rd = '0; disp = '0; pc_next = '0;
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0); chk("R1 wr_stb", wr_stb, 0);
    chk("R1 flags", {n_we, v_we, z_we}, 0); chk("R1 br", br_taken, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-release", {done, wr_stb, n_we, br_taken}, 0);

    // R2 / R3 / R4 / R5 / R6 sweeps
    for (int a = 0; a < 256; a += 7) begin
      for (int m = 0; m < 256; m++) begin
        logic [7:0] av, mv, w;
        av = 8'(a); mv = 8'(m);
        issue(3'd0, 8'h24, av, ~av, mv, 8'h00, 16'h0);
        chk("R2 we", {wr_stb, n_we, v_we, z_we}, 4'b0111);
        chk("R2 flags", {n_val, v_val, z_val}, {mv[7], mv[6], (av & mv) == 0});
        issue(3'd1, 8'h89, ~av, av, mv, 8'h00, 16'h0);
        chk("R3 we", {wr_stb, n_we, v_we, z_we}, 4'b0111);
        chk("R3 flags", {n_val, v_val, z_val}, {mv[7], mv[6], (av & mv) == 0});
        issue(3'd2, 8'h04, av, 8'h00, mv, 8'h00, 16'h0);
        w = av | mv;
        chk("R4 data", {wr_stb, wr_data}, {1'b1, w});
        chk("R6 set flags", {n_we, v_we, z_we, n_val, v_val, z_val},
            {3'b111, w[7], w[6], w == 0});
        issue(3'd3, 8'h14, av, 8'h00, mv, 8'h00, 16'h0);
        w = mv & ~av;
        chk("R5 data", {wr_stb, wr_data}, {1'b1, w});
        chk("R6 reset flags", {n_we, v_we, z_we, n_val, v_val, z_val},
            {3'b111, w[7], w[6], w == 0});
      end
    end

    // R7 / R8 / R9 sweeps over all bit numbers, both polarities, all operands
    for (int pl = 0; pl < 2; pl++) begin
      for (int n = 0; n < 8; n++) begin
        for (int m = 0; m < 256; m++) begin
          logic [7:0]  o, mv, dv, w;
          logic [15:0] pv, tg;
          mv = 8'(m); o = {pl[0], n[2:0], 4'h7};
          w = pl[0] ? (mv | (8'h1 << n)) : (mv & ~(8'h1 << n));
          issue(3'd4, o, 8'hA5, 8'h3C, mv, 8'h00, 16'h0);
          chk("R7 data", {wr_stb, wr_data}, {1'b1, w});
          chk("R7 no flags", {n_we, v_we, z_we, br_taken}, 0);
          dv = mv ^ 8'h5A; pv = 16'(m * 257 + n * 31);
          tg = pv + {{8{dv[7]}}, dv};
          o = {pl[0], n[2:0], 4'hF};
          issue(3'd5, o, 8'hFF, 8'hFF, mv, dv, pv);
          chk("R8 taken", br_taken, mv[n] == pl[0]);
          chk("R8 quiet", {wr_stb, n_we, v_we, z_we}, 0);
          chk("R9 target", br_target, tg);
        end
      end
    end

    // R9 wrap corners
    issue(3'd5, 8'h8F, 8'h0, 8'h0, 8'h01, 8'h7F, 16'hFFF0);
    chk("R9 wrap up", br_target, 16'h006F);
    issue(3'd5, 8'h0F, 8'h0, 8'h0, 8'h00, 8'h80, 16'h0010);
    chk("R9 wrap down", br_target, 16'hFF90);

    // R10 single-cycle results
    issue(3'd2, 8'h04, 8'h01, 8'h00, 8'h00, 8'h00, 16'h0);
    chk("R10 result", {done, wr_stb}, 2'b11);
    @(negedge clk);
    chk("R10 idle", {done, wr_stb, n_we, v_we, z_we, br_taken}, 0);

    // R11 unassigned kinds
    for (int k = 6; k < 8; k++) begin
      issue(3'(k), 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h10, 16'h1234);
      chk("R11 quiet", {done, wr_stb, n_we, v_we, z_we, br_taken}, 6'b100000);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule